// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the low-order address bits of a fixed-length burst for a synchronous memory front end. When the surrounding address-strobe logic accepts a new access, it pulses `load` and presents the low bits of the external address on `ext_addr`. The block captures that value as the burst start and steps through the remaining beats on each clock in which the active-low advance input is low. While advance is high, the burst is suspended and the current address is held.

The visiting order is picked by `order_sel`. Linear order adds the beat count to the start value and wraps within the burst. Interleaved order XORs the start value with the beat count. The block keeps the start value and a beat count in separate registers. It derives the registered address output from them, and it also exposes the beat count. The upper address register, the storage array and the chip-enable decoding live outside. They reach this block only through `load` and `adv_n`.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge sets `addr_lo` and `beat_idx` to 0 after that edge.
- R2: With `order_sel` = 0 (linear), `addr_lo` = (start + `beat_idx`) modulo 2^AW. With AW = 2 and start 01, the four beats read 01, 10, 11, 00.
- R3: With `order_sel` = 1 (interleaved), `addr_lo` = start XOR `beat_idx`. With AW = 2 and start 01, the four beats read 01, 00, 11, 10.
- R4: `order_sel` is sampled at every clock edge, and `addr_lo` is rebuilt from it after that edge. A change of order during a suspended burst therefore remaps the held address without moving the beat count.
- R5: When `load` = 1 at an edge, the start value becomes `ext_addr`. After that edge `beat_idx` = 0 and `addr_lo` = `ext_addr` in either order.
- R6: When `load` = 0 and `adv_n` = 0 at an edge, `beat_idx` increases by one modulo 2^AW.
- R7: When `load` = 0 and `adv_n` = 1 at an edge, `beat_idx` and the start value are unchanged. If `order_sel` is also unchanged, `addr_lo` is unchanged.
- R8: An advance from the last beat (`beat_idx` = 2^AW-1) returns `beat_idx` to 0 and `addr_lo` to the loaded start, so the beat after the last one repeats the first address.
- R9: When `load` = 1 and `adv_n` = 0 at the same edge, the load wins: the step is discarded and `beat_idx` = 0.
- R10: Loads on consecutive edges each take effect, with no advance needed between them. Each one replaces the start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Accepted burst start; captures `ext_addr` |
| adv_n | input | 1 | Advance enable, active low |
| ext_addr | input | AW | Low bits of the external address |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_lo | output | AW | Registered low address for the current beat |
| beat_idx | output | AW | Registered beat count since the last load |

## Verification
The bench targets the wrap from the last beat. A design that failed to wrap there would step past the start address or saturate instead of repeating the first address. It pairs `load` with an asserted advance in the same cycle: if advance wins, the new burst starts at beat 1. It applies back-to-back loads, which expose a start register that only updates after an advance. It also toggles the order during a suspended burst. A design that latched the order at load time would keep the stale address, and one that stepped on hold would move the beat count. Randomized traffic then mixes all of these, with a cycle-accurate model that computes each beat as an integer sum or XOR.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

endpackage

// File: rtl/burst_start_reg.sv
// Holds the start value of the current burst.
module burst_start_reg #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] start_nxt,
  output logic [AW-1:0] start_q
);

  always_comb begin
    start_nxt = start_q;
    if (rst) begin
      start_nxt = '0;
    end else if (load) begin
      start_nxt = ext_addr;
    end
  end

  always_ff @(posedge clk) begin
    start_q <= start_nxt;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter: cleared by a load, stepped by an active-low advance.
module burst_beat_ctr #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv_n,
  output logic [AW-1:0] beat_nxt,
  output logic [AW-1:0] beat_q
);

  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    beat_nxt = beat_q;
    if (rst || load) begin
      beat_nxt = '0;
    end else if (!adv_n) begin
      beat_nxt = beat_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    beat_q <= beat_nxt;
  end

endmodule

// File: rtl/burst_order_map.sv
// Maps a start value and beat count to an address in the chosen order.
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          order,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] beat,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] lin_addr;
  logic [AW-1:0] xor_addr;

  assign lin_addr = start + beat;

  for (genvar b = 0; b < AW; b++) begin : g_xor_bit
    assign xor_addr[b] = start[b] ^ beat[b];
  end

  always_comb begin
    if (order_e'(order) == ORD_XOR) begin
      addr = xor_addr;
    end else begin
      addr = lin_addr;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
// Burst low-address sequencer: top level.
module burst_addr_seq #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          order_sel,
  output logic [AW-1:0] addr_lo,
  output logic [AW-1:0] beat_idx
);

  logic [AW-1:0] start_nxt;
  logic [AW-1:0] start_q;
  logic [AW-1:0] beat_nxt;
  logic [AW-1:0] beat_q;
  logic [AW-1:0] addr_nxt;
  logic [AW-1:0] addr_q;

  burst_start_reg #(.AW(AW)) u_start (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ext_addr  (ext_addr),
    .start_nxt (start_nxt),
    .start_q   (start_q)
  );

  burst_beat_ctr #(.AW(AW)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .adv_n    (adv_n),
    .beat_nxt (beat_nxt),
    .beat_q   (beat_q)
  );

  burst_order_map #(.AW(AW)) u_map (
    .order (order_sel),
    .start (start_nxt),
    .beat  (beat_nxt),
    .addr  (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_nxt;
    end
  end

  assign addr_lo  = addr_q;
  assign beat_idx = beat_q;

  // start_q is only consumed through start_nxt; keep it observable.
  logic unused_start;
  assign unused_start = ^start_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          adv_n,
  input logic [AW-1:0] ext_addr,
  input logic          order_sel,
  input logic [AW-1:0] addr_lo,
  input logic [AW-1:0] beat_idx
);

  logic [AW-1:0] lin_off;
  logic [AW-1:0] xor_off;
  logic [AW-1:0] beat_inc;

  assign lin_off  = addr_lo - beat_idx;
  assign xor_off  = addr_lo ^ beat_idx;
  assign beat_inc = beat_idx + AW'(1);

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_lo == '0 && beat_idx == '0));

  // R5
  p_load_start_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_idx == '0 && addr_lo == $past(ext_addr)));

  // R6
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> (beat_idx == $past(beat_inc)));

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(beat_idx));

  // R9
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (load && !adv_n) |=> (beat_idx == '0));

  // R2: start recovered from a linear address stays constant within a burst
  p_linear_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && !order_sel && !$past(order_sel)) |=> $stable(lin_off));

  // R3: start recovered from an interleaved address stays constant
  p_xor_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && order_sel && $past(order_sel)) |=> $stable(xor_off));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .adv_n     (adv_n),
  .ext_addr  (ext_addr),
  .order_sel (order_sel),
  .addr_lo   (addr_lo),
  .beat_idx  (beat_idx)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int  AW      = 2;
  localparam int  NBEAT   = 1 << AW;
  localparam time CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic          adv_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_lo;
  logic [AW-1:0] beat_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PER / 2) clk = ~clk;

  burst_addr_seq #(.AW(AW)) i_burst_addr_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .adv_n     (adv_n),
    .ext_addr  (ext_addr),
    .order_sel (order_sel),
    .addr_lo   (addr_lo),
    .beat_idx  (beat_idx)
  );

  // Behavioural reference model
  int    m_start = 0;
  int    m_beat  = 0;
  int    m_addr  = 0;
  bit    prev_load = 0;
  int    prev_ord  = 0;
  string tag_addr = "R1";
  string tag_beat = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_beat = 0; m_addr = 0;
      tag_addr = "R1"; tag_beat = "R1";
      prev_load = 0;
    end else begin
      if (load) begin
        m_start = int'(ext_addr);
        m_beat  = 0;
        if (!adv_n)          begin tag_addr = "R9";  tag_beat = "R9";  end
        else if (prev_load)  begin tag_addr = "R10"; tag_beat = "R10"; end
        else                 begin tag_addr = "R5";  tag_beat = "R5";  end
      end else if (!adv_n) begin
        if (m_beat == NBEAT - 1) begin
          m_beat = 0; tag_addr = "R8"; tag_beat = "R8";
        end else begin
          m_beat = m_beat + 1;
          tag_addr = order_sel ? "R3" : "R2";
          tag_beat = "R6";
        end
      end else begin
        tag_beat = "R7";
        tag_addr = (int'(order_sel) != prev_ord) ? "R4" : "R7";
      end
      if (order_sel) m_addr = m_start ^ m_beat;
      else           m_addr = (m_start + m_beat) % NBEAT;
      prev_load = load;
    end
    prev_ord = int'(order_sel);
  end

  task automatic compare();
    n_cmp++;
    if (int'(addr_lo) != m_addr) begin
      n_bad++;
      $display("FAIL %s addr_lo: actual %0d expected %0d at %0t",
               tag_addr, addr_lo, m_addr, $time);
    end
    n_cmp++;
    if (int'(beat_idx) != m_beat) begin
      n_bad++;
      $display("FAIL %s beat_idx: actual %0d expected %0d at %0t",
               tag_beat, beat_idx, m_beat, $time);
    end
  endtask

  // Drive at a negedge, let one posedge pass, compare at the next negedge.
  task automatic cyc(input bit l, input bit an, input int ea, input bit ord);
    load = l; adv_n = an; ext_addr = AW'(ea); order_sel = ord;
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc(0, 1, 0, 0);          // R1 reset state
    cyc(0, 0, 3, 1);          // R1 advance ignored under reset
    rst = 1'b0;

    // R2 linear from 01: 01 10 11 00 then R8 wrap to 01
    cyc(1, 1, 1, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0);

    // R3 interleaved from 01: 01 00 11 10 then R8 wrap
    cyc(1, 1, 1, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);

    // R7 suspend, then R4 order change while suspended
    cyc(1, 1, 2, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 1);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1);

    // R9 load with advance in the same cycle
    cyc(0, 0, 0, 0);
    cyc(1, 0, 3, 0);
    cyc(1, 0, 2, 1);

    // R10 back-to-back loads
    cyc(1, 1, 0, 0);
    cyc(1, 1, 3, 0);
    cyc(1, 1, 1, 1);
    cyc(0, 0, 0, 1);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 99));
      if (i == 200) begin
        rst = 1'b1; cyc(0, 0, 0, 0); rst = 1'b0;
      end
      cyc(r < 20, ($urandom_range(0, 3) == 0),
          int'($urandom_range(0, NBEAT - 1)),
          (r % 7) < 3 ? order_sel : ~order_sel);
    end
    done = 1;
    finish_run();
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

endmodule